// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide host-side front end of a three-channel interval timer. A host sees four byte addresses. Three of them are per-channel data ports and one is a write-only control port. The block holds each channel's counting mode, byte-access mode and BCD flag. It assembles 16-bit reload values from single bytes or from low/high byte pairs and presents each finished value with a one-cycle load strobe to the counter datapath of its channel.

On the read side, the block returns either the channel's live count or a frozen snapshot of it. The live count and the output level are supplied by the counter datapath. A plain latch command freezes the count of one channel. A read-back command can freeze the count, a status byte, or both, for any set of channels in a single write. A pending status byte is always returned before a pending count snapshot. The counters themselves and decimal counting are outside this block. The BCD bit is only stored and reported.

Top module: `tmr_host_if`

## Requirements
- R1: After a synchronous reset every channel reports access mode 3 (low then high byte), counting mode 0 and BCD 0. No load strobe is active and nothing is latched.
- R2: A control write (address 3) with channel field bits 7:6 = n < 3 and access field bits 5:4 ≠ 0 sets channel n's access mode to bits 5:4, its counting mode to bits 3:1 and its BCD flag to bit 0. Other channels are unchanged and no load strobe follows.
- R3: With access mode 1, a data write of byte b to address n gives load value 0x00b on channel n. With access mode 2 it gives 0xb00. In both cases the strobe is high for exactly the one cycle after the write.
- R4: With access mode 3, the first data byte produces no strobe. The second byte produces load value {second, first}, and the next byte is again taken as a low byte.
- R5: A control write with access field 0 snapshots channel n's live count. Later reads return the snapshot, not the live value. A further latch request while the snapshot is not fully read leaves the snapshot unchanged.
- R6: A snapshot taken in access mode 3 reads out low byte, then high byte, and is then released. A snapshot taken in mode 1 or mode 2 is released after its one byte. Reads after release return live count bytes.
- R7: Without a snapshot, reads return the live low byte (mode 1) or the live high byte (mode 2). In mode 3 they alternate between low and high, starting with low.
- R8: A control write with bits 7:6 = 3 is a read-back command. Bit 1+n selects channel n. Bit 5 = 0 latches the count, following the R5 rules. Bit 4 = 0 latches status. Several channels can be selected in one command.
- R9: The status byte is {output level, 0, access[1:0], mode[2:0], bcd}. A pending status is returned before any count snapshot, and reading it clears it.
- R10: A status latch request while a status byte is still pending leaves the pending byte unchanged.
- R11: A read at address 3 returns 0 and changes no channel state.
- R12: Any control write that reconfigures a channel restarts both its write byte sequence and its read byte sequence at the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register address: 0 to 2 are data ports, 3 is control |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle rd_en is high |
| live_count | input | 48 | Live counts, channel n at bits 16n+15:16n |
| chan_out | input | 3 | Output level of each channel |
| load_stb | output | 3 | One-cycle reload strobe per channel |
| load_val | output | 48 | Reload values, channel n at bits 16n+15:16n |
| ch_mode | output | 9 | Counting mode, channel n at bits 3n+2:3n |
| ch_access | output | 6 | Access mode, channel n at bits 2n+1:2n |
| ch_bcd | output | 3 | BCD flag per channel |

## Verification
The assertions assume that the host never raises rd_en and wr_en in the same cycle; when it does, the block drops the read. They also assume that each strobe names a single byte transfer. The stimulus drives one transfer per cycle, on the falling clock edge, and always leaves at least one idle or transfer cycle between a latch command and the reads that depend on it. The live counts and output levels are changed only on falling edges, so the value a latch captures is the value the reference model recorded.

// File: rtl/tmr_pkg.sv
// Shared types for the timer host interface.
// Assumes a byte-wide host bus and 16-bit counters.
package tmr_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = 2 * BYTE_W;
    localparam int unsigned MODE_W = 3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LSB   = 2'd1,
        ACC_MSB   = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        HELD_NONE = 2'd0,
        HELD_LSB  = 2'd1,
        HELD_MSB  = 2'd2,
        HELD_WORD = 2'd3
    } held_e;

    typedef struct packed {
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } cfg_t;
endpackage

// File: rtl/tmr_ctrl_decode.sv
// Control-word decoder: turns a control-port write into per-channel
// configure, count-latch and status-latch requests.
// Assumes NUM_CH <= 3 so that the read-back select bits fit in the byte.
module tmr_ctrl_decode
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_CH = 3
) (
    input  logic              ctl_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [NUM_CH-1:0] cfg_we,
    output logic [NUM_CH-1:0] cnt_req,
    output logic [NUM_CH-1:0] sts_req,
    output cfg_t              cfg_val
);
    localparam logic [1:0] RB_CODE = 2'b11;

    logic [1:0] sel;
    logic       is_rb;
    acc_e       acc_f;

    // Field extraction of the control byte.
    always_comb begin
        sel     = wdata[7:6];
        is_rb   = (sel == RB_CODE);
        acc_f   = acc_e'(wdata[5:4]);
        cfg_val = '{acc: acc_f, mode: wdata[3:1], bcd: wdata[0]};
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic hit;
        // Per-channel request generation for direct and read-back commands.
        always_comb begin
            hit        = ctl_we && !is_rb && (sel == 2'(n));
            cfg_we[n]  = hit && (acc_f != ACC_LATCH);
            cnt_req[n] = (hit && (acc_f == ACC_LATCH))
                      || (ctl_we && is_rb && wdata[1+n] && !wdata[5]);
            sts_req[n] = ctl_we && is_rb && wdata[1+n] && !wdata[4];
        end
    end
endmodule

// File: rtl/tmr_chan_regs.sv
// Per-channel register slice: configuration, write byte sequencing,
// count snapshot, status snapshot and read byte selection.
// Assumes data_we, data_re and cfg_we are mutually exclusive per cycle.
module tmr_chan_regs
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  cfg_t              cfg_in,
    input  logic              cnt_latch_req,
    input  logic              sts_latch_req,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_count,
    input  logic              out_level,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val,
    output cfg_t              cfg_q
);
    localparam cfg_t CFG_RST = '{acc: ACC_WORD, mode: '0, bcd: 1'b0};

    logic              wr_hi_q;
    logic [BYTE_W-1:0] hold_q;
    logic              rd_hi_q;
    held_e             held_q;
    logic [CNT_W-1:0]  lat_cnt_q;
    logic              sts_pend_q;
    logic [BYTE_W-1:0] sts_q;
    logic              live_rd;

    // Configuration register, written by a configure command.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= CFG_RST;
        else if (cfg_we) cfg_q <= cfg_in;
    end

    // Write byte sequencer and reload strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_hi_q  <= 1'b0;
            hold_q   <= '0;
            load_stb <= 1'b0;
            load_val <= '0;
        end else begin
            load_stb <= 1'b0;
            if (cfg_we) begin
                wr_hi_q <= 1'b0;
            end else if (data_we) begin
                unique case (cfg_q.acc)
                    ACC_LSB: begin
                        load_stb <= 1'b1;
                        load_val <= {{BYTE_W{1'b0}}, wdata};
                    end
                    ACC_MSB: begin
                        load_stb <= 1'b1;
                        load_val <= {wdata, {BYTE_W{1'b0}}};
                    end
                    ACC_WORD: begin
                        if (!wr_hi_q) begin
                            hold_q  <= wdata;
                            wr_hi_q <= 1'b1;
                        end else begin
                            load_stb <= 1'b1;
                            load_val <= {wdata, hold_q};
                            wr_hi_q  <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Count snapshot: captured only when none is held, released byte by byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q    <= HELD_NONE;
            lat_cnt_q <= '0;
        end else if (data_re && !sts_pend_q && (held_q != HELD_NONE)) begin
            held_q <= (held_q == HELD_WORD) ? HELD_MSB : HELD_NONE;
        end else if (cnt_latch_req && (held_q == HELD_NONE)) begin
            lat_cnt_q <= live_count;
            held_q    <= held_e'(cfg_q.acc);
        end
    end

    // Status snapshot: captured only when none is pending, cleared on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_pend_q <= 1'b0;
            sts_q      <= '0;
        end else if (data_re && sts_pend_q) begin
            sts_pend_q <= 1'b0;
        end else if (sts_latch_req && !sts_pend_q) begin
            sts_q      <= {out_level, 1'b0, cfg_q.acc, cfg_q.mode, cfg_q.bcd};
            sts_pend_q <= 1'b1;
        end
    end

    // A read is "live" when neither snapshot is pending.
    always_comb live_rd = !sts_pend_q && (held_q == HELD_NONE);

    // Live read byte toggle for low/high access.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        rd_hi_q <= 1'b0;
        else if (cfg_we)                                   rd_hi_q <= 1'b0;
        else if (data_re && live_rd && cfg_q.acc == ACC_WORD) rd_hi_q <= ~rd_hi_q;
    end

    // Read byte selection: status first, then count snapshot, then live count.
    always_comb begin
        if (sts_pend_q) begin
            rd_byte = sts_q;
        end else begin
            unique case (held_q)
                HELD_LSB, HELD_WORD: rd_byte = lat_cnt_q[BYTE_W-1:0];
                HELD_MSB:            rd_byte = lat_cnt_q[CNT_W-1:BYTE_W];
                default: begin
                    if (cfg_q.acc == ACC_MSB || (cfg_q.acc == ACC_WORD && rd_hi_q))
                        rd_byte = live_count[CNT_W-1:BYTE_W];
                    else
                        rd_byte = live_count[BYTE_W-1:0];
                end
            endcase
        end
    end

    AST_STROBE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> $past(data_we)); // R3
    AST_LSB_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && cfg_q.acc == ACC_LSB) |=> (load_stb && load_val[CNT_W-1:BYTE_W] == '0)); // R3
    AST_WORD_FIRST_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && cfg_q.acc == ACC_WORD && !wr_hi_q) |=> !load_stb); // R4
    AST_SNAPSHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q != HELD_NONE && !data_re) |=> $stable(lat_cnt_q)); // R5
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_pend_q && !data_re) |=> (sts_pend_q && $stable(sts_q))); // R10
    AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (data_re && sts_pend_q) |=> $stable(held_q)); // R9
endmodule

// File: rtl/tmr_host_if.sv
// Top of the timer host interface: address decode, per-channel slices
// and the read multiplexer.
// Assumes at most one of rd_en / wr_en per cycle; a write wins.
module tmr_host_if
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_CH = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               addr,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [BYTE_W-1:0]        wdata,
    output logic [BYTE_W-1:0]        rdata,
    input  logic [NUM_CH*CNT_W-1:0]  live_count,
    input  logic [NUM_CH-1:0]        chan_out,
    output logic [NUM_CH-1:0]        load_stb,
    output logic [NUM_CH*CNT_W-1:0]  load_val,
    output logic [NUM_CH*MODE_W-1:0] ch_mode,
    output logic [NUM_CH*2-1:0]      ch_access,
    output logic [NUM_CH-1:0]        ch_bcd
);
    localparam logic [1:0] CTL_ADDR = 2'd3;

    logic              ctl_we;
    logic [NUM_CH-1:0] cfg_we;
    logic [NUM_CH-1:0] cnt_req;
    logic [NUM_CH-1:0] sts_req;
    cfg_t              cfg_val;
    logic [BYTE_W-1:0] rd_byte [NUM_CH];

    // Control port write detect.
    always_comb ctl_we = wr_en && (addr == CTL_ADDR);

    tmr_ctrl_decode #(.NUM_CH(NUM_CH)) u_dec (
        .ctl_we  (ctl_we),
        .wdata   (wdata),
        .cfg_we  (cfg_we),
        .cnt_req (cnt_req),
        .sts_req (sts_req),
        .cfg_val (cfg_val)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic dwe, dre;
        cfg_t cq;
        // Data port strobes of this channel; reads drop under a write.
        always_comb begin
            dwe = wr_en && (addr == 2'(n));
            dre = rd_en && !wr_en && (addr == 2'(n));
        end

        tmr_chan_regs u_chan (
            .clk           (clk),
            .rst_n         (rst_n),
            .cfg_we        (cfg_we[n]),
            .cfg_in        (cfg_val),
            .cnt_latch_req (cnt_req[n]),
            .sts_latch_req (sts_req[n]),
            .data_we       (dwe),
            .data_re       (dre),
            .wdata         (wdata),
            .live_count    (live_count[n*CNT_W +: CNT_W]),
            .out_level     (chan_out[n]),
            .rd_byte       (rd_byte[n]),
            .load_stb      (load_stb[n]),
            .load_val      (load_val[n*CNT_W +: CNT_W]),
            .cfg_q         (cq)
        );

        // Configuration fields brought out per channel.
        always_comb begin
            ch_mode[n*MODE_W +: MODE_W] = cq.mode;
            ch_access[n*2 +: 2]         = cq.acc;
            ch_bcd[n]                   = cq.bcd;
        end
    end

    // Read multiplexer; the control address reads as zero.
    always_comb begin
        rdata = '0;
        for (int n = 0; n < NUM_CH; n++)
            if (addr == 2'(n)) rdata = rd_byte[n];
    end

    AST_ONE_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_we)); // R2
    AST_NO_LOAD_ON_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (load_stb == '0)); // R2
endmodule

// File: tb/tmr_host_if_test.sv
module tmr_host_if_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  addr;
    logic        wr_en, rd_en;
    logic [7:0]  wdata, rdata;
    logic [47:0] live_count;
    logic [2:0]  chan_out;
    logic [2:0]  load_stb;
    logic [47:0] load_val;
    logic [8:0]  ch_mode;
    logic [5:0]  ch_access;
    logic [2:0]  ch_bcd;

    always #5 clk = ~clk;

    tmr_host_if uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .live_count(live_count), .chan_out(chan_out),
        .load_stb(load_stb), .load_val(load_val), .ch_mode(ch_mode),
        .ch_access(ch_access), .ch_bcd(ch_bcd)
    );

    int n_chk = 0, n_bad = 0;
    // Reference model state.
    int m_acc[3], m_mode[3], m_bcd[3], m_wrhi[3], m_hold[3], m_rdhi[3];
    int m_held[3], m_lc[3], m_sp[3], m_st[3];
    int lv[3];
    int e_stb, e_val[3];

    always_comb live_count = {lv[2][15:0], lv[1][15:0], lv[0][15:0]};

    task automatic chk(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic cmp_state();
        for (int c = 0; c < 3; c++) begin
            chk("R1 R2 access", int'(ch_access[c*2 +: 2]), m_acc[c]);
            chk("R1 R2 mode", int'(ch_mode[c*3 +: 3]), m_mode[c]);
            chk("R1 R2 bcd", int'(ch_bcd[c]), m_bcd[c]);
            if (e_stb[c]) chk("R3 R4 R12 load value", int'(load_val[c*16 +: 16]), e_val[c]);
        end
        chk("R2 R3 R4 load strobe", int'(load_stb), e_stb);
    endtask

    function automatic void m_write(int a, int d);
        if (a == 3) begin
            int sel = (d >> 6) & 3, acc = (d >> 4) & 3;
            if (sel != 3) begin
                if (acc == 0) begin
                    if (m_held[sel] == 0) begin m_lc[sel] = lv[sel]; m_held[sel] = m_acc[sel]; end
                end else begin
                    m_acc[sel] = acc; m_mode[sel] = (d >> 1) & 7; m_bcd[sel] = d & 1;
                    m_wrhi[sel] = 0; m_rdhi[sel] = 0;
                end
            end else begin
                for (int c = 0; c < 3; c++) if ((d >> (1 + c)) & 1) begin
                    if (!((d >> 5) & 1) && m_held[c] == 0) begin m_lc[c] = lv[c]; m_held[c] = m_acc[c]; end
                    if (!((d >> 4) & 1) && m_sp[c] == 0) begin
                        m_st[c] = (int'(chan_out[c]) << 7) | (m_acc[c] << 4) | (m_mode[c] << 1) | m_bcd[c];
                        m_sp[c] = 1;
                    end
                end
            end
        end else begin
            case (m_acc[a])
                1: begin e_stb |= 1 << a; e_val[a] = d; end
                2: begin e_stb |= 1 << a; e_val[a] = d << 8; end
                default: begin
                    if (!m_wrhi[a]) begin m_hold[a] = d; m_wrhi[a] = 1; end
                    else begin e_stb |= 1 << a; e_val[a] = (d << 8) | m_hold[a]; m_wrhi[a] = 0; end
                end
            endcase
        end
    endfunction

    function automatic int m_read(int a);
        int r;
        if (a > 2) return 0;
        if (m_sp[a]) begin m_sp[a] = 0; return m_st[a]; end
        case (m_held[a])
            1: begin m_held[a] = 0; return m_lc[a] & 255; end
            2: begin m_held[a] = 0; return (m_lc[a] >> 8) & 255; end
            3: begin m_held[a] = 2; return m_lc[a] & 255; end
            default: ;
        endcase
        case (m_acc[a])
            1: r = lv[a] & 255;
            2: r = (lv[a] >> 8) & 255;
            default: begin r = m_rdhi[a] ? (lv[a] >> 8) & 255 : lv[a] & 255; m_rdhi[a] ^= 1; end
        endcase
        return r;
    endfunction

    task automatic wr(int a, int d);
        @(negedge clk); cmp_state(); e_stb = 0;
        rd_en = 0; wr_en = 1; addr = 2'(a); wdata = 8'(d);
        m_write(a, d);
    endtask

    task automatic rd(int a, string req);
        int exp;
        @(negedge clk); cmp_state(); e_stb = 0;
        wr_en = 0; rd_en = 1; addr = 2'(a);
        #1; exp = m_read(a);
        chk(req, int'(rdata), exp);
    endtask

    task automatic idle();
        @(negedge clk); cmp_state(); e_stb = 0;
        wr_en = 0; rd_en = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int c = 0; c < 3; c++) begin
            m_acc[c] = 3; m_mode[c] = 0; m_bcd[c] = 0; m_wrhi[c] = 0; m_hold[c] = 0;
            m_rdhi[c] = 0; m_held[c] = 0; m_lc[c] = 0; m_sp[c] = 0; m_st[c] = 0;
            e_val[c] = 0; lv[c] = 0;
        end
        e_stb = 0; lv[0] = 'hBEEF; lv[1] = 'hCAFE; lv[2] = 'h0123;
        rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; chan_out = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle(); idle();                        // R1 reset state
        rd(3, "R11 control read");
        rd(0, "R1 R7 reset live low byte");
        rd(0, "R7 reset live high byte");
        wr(3, 'h14); wr(0, 'h5A); idle();      // R2 R3 ch0 lsb, mode 2
        wr(3, 'h67); wr(1, 'hC3); idle();      // R2 R3 ch1 msb, mode 3, bcd
        wr(3, 'hB8); wr(2, 'h34); wr(2, 'h12); idle(); // R4
        wr(2, 'h78); wr(2, 'h56); idle();      // R4 back to low byte
        wr(2, 'hAA); wr(3, 'hB8); wr(2, 'h11); wr(2, 'h22); idle(); // R12 write restart
        rd(0, "R7 lsb live"); rd(1, "R7 msb live");
        rd(2, "R7 word live low"); rd(2, "R7 word live high"); rd(2, "R7 word live low again");
        wr(3, 'hB8); rd(2, "R12 read restart low");
        wr(3, 'h80); idle();                   // R5 latch ch2
        lv[2] = 'h4567; idle();
        wr(3, 'h80); idle();                   // R5 ignored while held
        rd(2, "R5 R6 snapshot low"); rd(2, "R6 snapshot high");
        rd(2, "R6 released live"); rd(2, "R6 released live next");
        wr(3, 'h00); idle(); lv[0] = 'h1234; idle();
        rd(0, "R5 R6 lsb snapshot"); rd(0, "R6 lsb released");
        chan_out = 3'b101; idle();
        wr(3, 'hCE); idle();                   // R8 all channels, count and status
        lv[1] = 'h9876; lv[0] = 'h0F0F; idle();
        rd(1, "R8 R9 status ch1"); rd(1, "R8 R9 snapshot msb ch1"); rd(1, "R8 live ch1");
        rd(0, "R8 R9 status ch0"); rd(0, "R8 snapshot ch0"); rd(0, "R8 live ch0");
        rd(2, "R8 R9 status ch2"); rd(2, "R8 snapshot low ch2"); rd(2, "R8 snapshot high ch2");
        wr(3, 'hE8); idle(); chan_out = 3'b001; idle();
        wr(3, 'hE8); idle();                   // R10 second status request ignored
        rd(2, "R10 pending status kept"); rd(2, "R10 status cleared, live read");
        wr(3, 'hD4); idle();                   // R8 count only ch1, status only none
        rd(3, "R11 control read during snapshot"); rd(3, "R11 second control read");
        rd(1, "R11 snapshot intact ch1"); rd(1, "R6 released ch1");
        idle(); idle();
        finish_run();
    end
endmodule